// File: doc/BRIEF.md
# Clock Configuration Serial Slave

This block is the write-only configuration port of a clock generator. It listens on a two-wire serial bus (SMBus-style), sampling SCL and SDA with a faster system clock. It accepts write transactions addressed to the fixed 7-bit address 1101001 and acknowledges the address and every data byte. The first four data bytes of each transaction are thrown away. The next three bytes load three 8-bit control registers, which drive the clock output enables and the generator mode bits as parallel outputs.

The control registers come out of reset with the clock outputs enabled and spread spectrum off. Surrounding logic uses the register-select bit to choose between these register values and the strap pins. A START or STOP anywhere on the bus abandons the byte being shifted in. Reads, clock stretching and pad electricals are outside this block.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: After reset, `out_en_a` and `out_en_b` are 8'hFF and `gen_mode` is 8'h7D (bit 7 = 0, bits 6..2 = 1, bit 1 = 0, bit 0 = 1).
- R2: After a START, an address byte of 1101001 followed by a 0 (write) bit is acknowledged. The acknowledgement is `sda_pull` = 1 from the eighth SCL falling edge until the ninth SCL falling edge, so the bus reads low while SCL is high in the ninth clock.
- R3: An address byte whose upper seven bits differ from 1101001 is not acknowledged, and the data that follows changes no register.
- R4: An address byte with the correct address and the read bit (bit 0) set to 1 is not acknowledged and changes no register.
- R5: Data bytes arrive MSB first and are counted from 0 after the address. Bytes 0 to 3 are acknowledged and discarded. Byte 4 loads `out_en_a`, byte 5 loads `out_en_b` and byte 6 loads `gen_mode`, each at the moment its eighth bit is sampled. The registers change at no other time.
- R6: Data bytes after byte 6 are acknowledged and discarded.
- R7: A STOP in the middle of a byte abandons that byte: no register takes its partial value, and `sda_pull` is released.
- R8: A repeated START resets the byte counter, so the next write again discards its first four data bytes.
- R9: A write that ends before byte 4 leaves all registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| out_en_a | output | 8 | Byte-4 register: ref0, USB/IO, USB0, AGP1, AGP0, CPU pairs 2..0 (bit 7 to bit 0) |
| out_en_b | output | 8 | Byte-5 register: ref1 at bit 7, PCI clocks 6..0 at bits 6..0 |
| gen_mode | output | 8 | Byte-6 register: bit 7 spread enable, bits 6:4 mode (test, FS1, FS0), bit 1 register select, bit 0 SDRAM output enable |

## Verification
The bench builds the block with its default parameters: address 1101001 and four discarded leading bytes. It therefore reaches the exact byte positions at which the three registers load. It also reaches the saturating byte counter that takes trailing bytes past byte 6. SCL is held for ten system clocks per quarter bit, well above the synchroniser latency. This lets the acknowledge window and mid-byte STOP and repeated START cases be checked at the pins.

// File: rtl/clkcfg_serial_slave.sv
module clkcfg_serial_slave #(
  parameter logic [6:0] ADDR     = 7'b1101001,
  parameter int         SKIP     = 4,
  parameter logic [7:0] RST_A    = 8'hFF,
  parameter logic [7:0] RST_B    = 8'hFF,
  parameter logic [7:0] RST_MODE = 8'h7D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       sda_pull,
  output logic [7:0] out_en_a,
  output logic [7:0] out_en_b,
  output logic [7:0] gen_mode
);
  localparam int CW = $clog2(SKIP + 4);
  localparam logic [CW-1:0] IDX_A   = CW'(SKIP);
  localparam logic [CW-1:0] IDX_B   = CW'(SKIP + 1);
  localparam logic [CW-1:0] IDX_M   = CW'(SKIP + 2);
  localparam logic [CW-1:0] IDX_SAT = CW'(SKIP + 3);

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_ACKW, S_ACKD} state_t;

  state_t        state;
  logic [1:0]    scl_q, sda_q;
  logic          scl_p, sda_p;
  logic [6:0]    shreg;
  logic [2:0]    bitcnt;
  logic [CW-1:0] bytecnt;
  logic          addr_ph;

  wire scl_s     = scl_q[1];
  wire sda_s     = sda_q[1];
  wire scl_rise  = scl_s & ~scl_p;
  wire scl_fall  = ~scl_s & scl_p;
  wire start_det = scl_s & scl_p & sda_p & ~sda_s;
  wire stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  wire [7:0] nxt = {shreg, sda_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 2'b11;
      sda_q    <= 2'b11;
      scl_p    <= 1'b1;
      sda_p    <= 1'b1;
      state    <= S_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      bytecnt  <= '0;
      addr_ph  <= 1'b0;
      sda_pull <= 1'b0;
      out_en_a <= RST_A;
      out_en_b <= RST_B;
      gen_mode <= RST_MODE;
    end else begin
      scl_q <= {scl_q[0], scl_in};
      sda_q <= {sda_q[0], sda_in};
      scl_p <= scl_s;
      sda_p <= sda_s;
      if (start_det) begin
        state    <= S_RECV;
        addr_ph  <= 1'b1;
        bitcnt   <= '0;
        bytecnt  <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= S_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          S_RECV: if (scl_rise) begin
            shreg  <= nxt[6:0];
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) begin
              if (addr_ph) begin
                state <= (nxt == {ADDR, 1'b0}) ? S_ACKW : S_IDLE;
              end else begin
                if (bytecnt == IDX_A) out_en_a <= nxt;
                if (bytecnt == IDX_B) out_en_b <= nxt;
                if (bytecnt == IDX_M) gen_mode <= nxt;
                if (bytecnt != IDX_SAT) bytecnt <= bytecnt + 1'b1;
                state <= S_ACKW;
              end
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_pull <= 1'b1;
            state    <= S_ACKD;
          end
          S_ACKD: if (scl_fall) begin
            sda_pull <= 1'b0;
            addr_ph  <= 1'b0;
            bitcnt   <= '0;
            state    <= S_RECV;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assert_ack_starts_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));
  assert_idle_no_pull_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !sda_pull);
  assert_regs_load_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_rise |=> $stable({out_en_a, out_en_b, gen_mode}));
  assert_stop_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);
  assert_start_clears_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (bytecnt == '0));
endmodule

// File: tb/clkcfg_serial_slave_bench.sv
module clkcfg_serial_slave_bench;
  localparam int Q = 10;
  localparam logic [7:0] WADDR = {7'b1101001, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic [7:0] out_en_a, out_en_b, gen_mode;
  wire  sda_line = sda_m & ~sda_pull;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  clkcfg_serial_slave u_clkcfg_serial_slave (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
    .sda_pull(sda_pull), .out_en_a(out_en_a), .out_en_b(out_en_b), .gen_mode(gen_mode));

  localparam logic [23:0] VEC [4] = '{24'h12_34_56, 24'hA5_5A_80, 24'h00_FF_0F, 24'hC3_3C_E2};

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b0; wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wq(Q);
    scl = 1'b1;   wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl = 1'b1;   wq(2 * Q);
      scl = 1'b0;   wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl = 1'b1;   wq(Q);
    ack = ~sda_line;
    wq(Q);
    scl = 1'b0;   wq(Q);
  endtask

  task automatic snap(input string tag, input logic [7:0] a, input logic [7:0] b, input logic [7:0] m);
    wq(8);
    check({tag, " out_en_a"}, out_en_a, a);
    check({tag, " out_en_b"}, out_en_b, b);
    check({tag, " gen_mode"}, gen_mode, m);
  endtask

  initial begin
    wq(200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] ea, eb, em;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    // R1 reset values
    snap("R1 reset", 8'hFF, 8'hFF, 8'h7D);
    ea = 8'hFF; eb = 8'hFF; em = 8'h7D;

    // R3 foreign address
    bus_start;
    send_byte(8'h52, ack);
    check("R3 nack foreign address", {7'd0, ack}, 8'd0);
    for (int k = 0; k < 7; k++) send_byte(8'h11, ack);
    bus_stop;
    snap("R3 no change", ea, eb, em);

    // R4 read bit set
    bus_start;
    send_byte({7'b1101001, 1'b1}, ack);
    check("R4 nack read", {7'd0, ack}, 8'd0);
    for (int k = 0; k < 7; k++) send_byte(8'h22, ack);
    bus_stop;
    snap("R4 no change", ea, eb, em);

    // R2/R5 vector table walk
    for (int v = 0; v < 4; v++) begin
      bus_start;
      send_byte(WADDR, ack);
      check("R2 address ack", {7'd0, ack}, 8'd1);
      for (int k = 0; k < 4; k++) begin
        send_byte(8'hE7 ^ 8'(k), ack);
        check("R5 skipped byte ack", {7'd0, ack}, 8'd1);
      end
      send_byte(VEC[v][23:16], ack);
      send_byte(VEC[v][15:8], ack);
      send_byte(VEC[v][7:0], ack);
      check("R2 data ack", {7'd0, ack}, 8'd1);
      bus_stop;
      ea = VEC[v][23:16]; eb = VEC[v][15:8]; em = VEC[v][7:0];
      snap("R5 load", ea, eb, em);
    end

    // R6 trailing bytes
    bus_start;
    send_byte(WADDR, ack);
    for (int k = 0; k < 4; k++) send_byte(8'h00, ack);
    send_byte(8'h81, ack); send_byte(8'h42, ack); send_byte(8'h24, ack);
    send_byte(8'hDB, ack);
    check("R6 byte 7 ack", {7'd0, ack}, 8'd1);
    send_byte(8'hBD, ack);
    check("R6 byte 8 ack", {7'd0, ack}, 8'd1);
    bus_stop;
    ea = 8'h81; eb = 8'h42; em = 8'h24;
    snap("R6 trailing discarded", ea, eb, em);

    // R9 short write
    bus_start;
    send_byte(WADDR, ack);
    for (int k = 0; k < 4; k++) send_byte(8'h99, ack);
    bus_stop;
    snap("R9 short write", ea, eb, em);

    // R7 stop mid byte
    bus_start;
    send_byte(WADDR, ack);
    for (int k = 0; k < 4; k++) send_byte(8'h00, ack);
    send_byte(8'h3C, ack);
    send_bits(8'h00, 5);
    bus_stop;
    ea = 8'h3C;
    check("R7 pull released", {7'd0, sda_pull}, 8'd0);
    snap("R7 partial dropped", ea, eb, em);

    // R8 repeated start
    bus_start;
    send_byte(WADDR, ack);
    for (int k = 0; k < 3; k++) send_byte(8'h00, ack);
    bus_start;
    send_byte(WADDR, ack);
    check("R8 ack after restart", {7'd0, ack}, 8'd1);
    for (int k = 0; k < 4; k++) send_byte(8'h66, ack);
    send_byte(8'h5A, ack);
    bus_stop;
    ea = 8'h5A;
    snap("R8 counter reset", ea, eb, em);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule